// File: doc/BRIEF.md
# Indirect-indexed codec register file

This block is the memory-mapped control-register file of an audio codec. A simple 32-bit bus with address, write enable, write data, read enable and read data reaches sixteen direct 32-bit words. It also reaches thirty-two 8-bit indirect registers. Software loads an index into direct word 0. It then reads or writes direct word 1, which acts as a window onto the indirect register that the index selects.

Some locations have fixed access rules:
- Indirect register 3 is write-only.
- Indirect registers 11 and 25 are read-only.
- Indirect register 12 holds a fixed codec version code in all bits except one writable bit.
- Direct word 2 is read-only.

Direct word 4 is a control word. Writing it with bit 0 set performs a software reset of the whole register file in that same cycle. An active-low asynchronous hardware reset applies the same reset values. Reads are combinational.

Top module: `codec_regfile`

## Requirements
- R1: The word select is address bits [5:2]. Address bits [1:0] and all bits above bit 5 have no effect on which word is accessed.
- R2: A write to direct word 0, 3, 5, 6, 7, 8, 9, 10, 11, 12, 13, 14 or 15 stores all 32 data bits. A later read of that word returns the stored value unchanged.
- R3: Bits [4:0] of direct word 0 form the index. A read of word 1 returns the indexed 8-bit indirect register, zero-extended to 32 bits. A write to word 1 stores data bits [7:0] into the indexed register.
- R4: While the index is 3, a read of word 1 returns zero. A write to word 1 at index 3 is still accepted.
- R5: Writes to word 1 while the index is 11 or 25 leave those registers unchanged.
- R6: A write to word 1 at index 12 stores (data & 0x40) | 0x8A.
- R7: After hardware reset (rst_ni low), every direct word and every indirect register reads 0. The exceptions are indirect register 12, which reads 0x8A, and indirect register 25, which reads 0xA0.
- R8: Direct word 2 always reads 0. Writes to it have no effect.
- R9: A write to word 4 with data bit 0 set returns every register to its R7 value on that clock edge. The one exception is word 4, which takes data & 0x7F.
- R10: A write to word 4 with data bit 0 clear stores data & 0x7F and disturbs no other register.
- R11: rdata_o shows the addressed value combinationally in the cycle re_i is high. It is 0 whenever re_i is low.
- R12: No register changes in a cycle where we_i is low, whatever the address and data are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 32 | Byte address; only bits [5:2] are decoded |
| we_i | input | 1 | Write enable, sampled on the rising clock edge |
| wdata_i | input | 32 | Write data |
| re_i | input | 1 | Read enable |
| rdata_o | output | 32 | Combinational read data |

## Verification
Some properties are checked by assertions on every cycle:
- Indirect register 12 keeps its fixed version field.
- The read-only indirect registers do not move when they are written.
- A read at index 3 or of word 2 returns zero, and an idle read bus returns zero.
- The control word keeps only its low seven bits.
- A software reset clears the index word.

Other behaviour is shown only by the bench scenarios:
- The full sweeps of the direct words, with junk in the upper address bits.
- The sweep of all thirty-two indices through the window.
- A software reset followed by a sweep of the reset values.
- The equivalence of hardware and software reset.

// File: rtl/codec_regfile_pkg.sv
package codec_regfile_pkg;
  localparam int DATA_W = 32;
  localparam int N_DIR  = 16;
  localparam int N_IND  = 32;
  localparam int IND_W  = 8;

  localparam int WORD_INDEX  = 0;
  localparam int WORD_WINDOW = 1;
  localparam int WORD_RO     = 2;
  localparam int WORD_CTRL   = 4;

  localparam int IDX_WRONLY = 3;
  localparam int IDX_RO_A   = 11;
  localparam int IDX_VER    = 12;
  localparam int IDX_CHIP   = 25;

  localparam logic [7:0]  CODEC_VER  = 8'h8A;
  localparam logic [7:0]  CHIP_ID    = 8'hA0;
  localparam logic [7:0]  VER_KEEP   = 8'h40;
  localparam logic [31:0] CTRL_MASK  = 32'h0000_007F;

  function automatic logic [7:0] ind_rst_val(input int i);
    if (i == IDX_VER)  return CODEC_VER;
    if (i == IDX_CHIP) return CHIP_ID;
    return 8'h00;
  endfunction
endpackage

// File: rtl/codec_direct_bank.sv
module codec_direct_bank
  import codec_regfile_pkg::*;
#(
  parameter int DW     = DATA_W,
  parameter int ND     = N_DIR,
  localparam int WSEL_W = $clog2(ND)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [WSEL_W-1:0]    wr_word_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic                 soft_rst_i,
  output logic [ND-1:0][DW-1:0] regs_o
);
  for (genvar w = 0; w < ND; w++) begin : g_word
    logic [DW-1:0] q;
    logic          hit;
    assign hit = wr_en_i && (wr_word_i == WSEL_W'(w));
    if (w == WORD_WINDOW || w == WORD_RO) begin : g_zero
      // window word has no storage; read-only word is tied low
      assign q = '0;
    end else if (w == WORD_CTRL) begin : g_ctrl
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  q <= '0;
        else if (hit) q <= wdata_i & DW'(CTRL_MASK);
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         q <= '0;
        else if (soft_rst_i) q <= '0;
        else if (hit)        q <= wdata_i;
      end
    end
    assign regs_o[w] = q;
  end

  // R9
  soft_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (regs_o[WORD_INDEX] == '0));

  // R10
  ctrl_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_word_i == WSEL_W'(WORD_CTRL)) |=>
      (regs_o[WORD_CTRL] == ($past(wdata_i) & DW'(CTRL_MASK))));
endmodule

// File: rtl/codec_indirect_bank.sv
module codec_indirect_bank
  import codec_regfile_pkg::*;
#(
  parameter int IW     = IND_W,
  parameter int NI     = N_IND,
  localparam int IDX_W = $clog2(NI)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [IW-1:0]        wdata_i,
  input  logic                 soft_rst_i,
  output logic [NI-1:0][IW-1:0] regs_o
);
  for (genvar i = 0; i < NI; i++) begin : g_ireg
    localparam logic [IW-1:0] RV = IW'(ind_rst_val(i));
    logic [IW-1:0] q;
    logic          hit;
    assign hit = wr_en_i && (idx_i == IDX_W'(i));
    if (i == IDX_RO_A || i == IDX_CHIP) begin : g_ro
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         q <= RV;
        else if (soft_rst_i) q <= RV;
      end
    end else if (i == IDX_VER) begin : g_ver
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         q <= RV;
        else if (soft_rst_i) q <= RV;
        else if (hit)        q <= (wdata_i & IW'(VER_KEEP)) | IW'(CODEC_VER);
      end
    end else begin : g_rw
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         q <= RV;
        else if (soft_rst_i) q <= RV;
        else if (hit)        q <= wdata_i;
      end
    end
    assign regs_o[i] = q;
  end

  // R6
  ver_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (regs_o[IDX_VER] & ~IW'(VER_KEEP)) == IW'(CODEC_VER));

  // R5
  ro_a_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && idx_i == IDX_W'(IDX_RO_A)) |=> $stable(regs_o[IDX_RO_A]));

  // R5
  ro_b_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && idx_i == IDX_W'(IDX_CHIP)) |=> $stable(regs_o[IDX_CHIP]));
endmodule

// File: rtl/codec_read_mux.sv
module codec_read_mux
  import codec_regfile_pkg::*;
#(
  parameter int DW     = DATA_W,
  parameter int ND     = N_DIR,
  parameter int IW     = IND_W,
  parameter int NI     = N_IND,
  localparam int WSEL_W = $clog2(ND),
  localparam int IDX_W  = $clog2(NI)
) (
  input  logic                  re_i,
  input  logic [WSEL_W-1:0]     word_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [ND-1:0][DW-1:0] dir_regs_i,
  input  logic [NI-1:0][IW-1:0] ind_regs_i,
  output logic [DW-1:0]         rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (re_i) begin
      if (word_i == WSEL_W'(WORD_WINDOW)) begin
        if (idx_i != IDX_W'(IDX_WRONLY)) rdata_o = DW'(ind_regs_i[idx_i]);
      end else begin
        rdata_o = dir_regs_i[word_i];
      end
    end
  end
endmodule

// File: rtl/codec_regfile.sv
module codec_regfile
  import codec_regfile_pkg::*;
#(
  parameter int DW     = DATA_W,
  parameter int ND     = N_DIR,
  parameter int IW     = IND_W,
  parameter int NI     = N_IND,
  parameter int AW     = 32,
  localparam int WSEL_W = $clog2(ND),
  localparam int IDX_W  = $clog2(NI)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  output logic [DW-1:0] rdata_o
);
  logic [WSEL_W-1:0]     word;
  logic [IDX_W-1:0]      idx;
  logic                  win_wr, dir_wr, soft_rst;
  logic [ND-1:0][DW-1:0] dir_regs;
  logic [NI-1:0][IW-1:0] ind_regs;
  logic                  unused_addr;

  assign word        = addr_i[WSEL_W+1:2];
  assign unused_addr = ^{addr_i[AW-1:WSEL_W+2], addr_i[1:0]};
  assign idx         = dir_regs[WORD_INDEX][IDX_W-1:0];
  assign win_wr      = we_i && (word == WSEL_W'(WORD_WINDOW));
  assign dir_wr      = we_i && !win_wr;
  assign soft_rst    = we_i && (word == WSEL_W'(WORD_CTRL)) && wdata_i[0];

  codec_direct_bank #(.DW(DW), .ND(ND)) u_dir (
    .clk_i, .rst_ni,
    .wr_en_i   (dir_wr),
    .wr_word_i (word),
    .wdata_i,
    .soft_rst_i(soft_rst),
    .regs_o    (dir_regs)
  );

  codec_indirect_bank #(.IW(IW), .NI(NI)) u_ind (
    .clk_i, .rst_ni,
    .wr_en_i   (win_wr),
    .idx_i     (idx),
    .wdata_i   (wdata_i[IW-1:0]),
    .soft_rst_i(soft_rst),
    .regs_o    (ind_regs)
  );

  codec_read_mux #(.DW(DW), .ND(ND), .IW(IW), .NI(NI)) u_rd (
    .re_i,
    .word_i    (word),
    .idx_i     (idx),
    .dir_regs_i(dir_regs),
    .ind_regs_i(ind_regs),
    .rdata_o
  );

  // R4
  wronly_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && word == WSEL_W'(WORD_WINDOW) && idx == IDX_W'(IDX_WRONLY)) |-> (rdata_o == '0));

  // R8
  ro_word_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && word == WSEL_W'(WORD_RO)) |-> (rdata_o == '0));

  // R11
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |-> (rdata_o == '0));

  // R12
  no_write_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(dir_regs) && $stable(ind_regs)));
endmodule

// File: tb/tb_codec_regfile.sv
module tb_codec_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic        re = 1'b0;
  logic [31:0] rdata;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  logic [31:0] m_dir [16];
  logic [7:0]  m_ind [32];

  always #2.5 clk = ~clk;

  codec_regfile dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .re_i(re), .rdata_o(rdata)
  );

  function automatic void m_reset();
    for (int i = 0; i < 16; i++) m_dir[i] = '0;
    for (int i = 0; i < 32; i++) m_ind[i] = (i == 12) ? 8'h8A : (i == 25) ? 8'hA0 : 8'h00;
  endfunction

  function automatic void m_write(input logic [31:0] a, input logic [31:0] d);
    int w;
    int ix;
    w  = int'(a[5:2]);
    ix = int'(m_dir[0][4:0]);
    case (w)
      1: begin
        if (ix == 12) m_ind[ix] = (d[7:0] & 8'h40) | 8'h8A;
        else if (ix != 11 && ix != 25) m_ind[ix] = d[7:0];
      end
      2: ;
      4: begin
        if (d[0]) m_reset();
        m_dir[4] = d & 32'h7F;
      end
      default: m_dir[w] = d;
    endcase
  endfunction

  function automatic logic [31:0] m_read(input logic [31:0] a);
    int w;
    int ix;
    w  = int'(a[5:2]);
    ix = int'(m_dir[0][4:0]);
    if (w == 1) return (ix == 3) ? 32'h0 : {24'h0, m_ind[ix]};
    return m_dir[w];
  endfunction

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    m_write(a, d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic chk(input logic [31:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    addr = a; re = 1'b1;
    #1;
    n_chk++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%h got=%h exp=%h", req, a, rdata, exp);
    end
    re = 1'b0;
  endtask

  task automatic chk_m(input logic [31:0] a, input string req);
    chk(a, m_read(a), req);
  endtask

  task automatic sweep_ind(input string req);
    for (int i = 0; i < 32; i++) begin
      wr(32'h0, i);
      chk_m(32'h4, req);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R7 reset state of direct words
    for (int w = 0; w < 16; w++) chk(32'(w) << 2, 32'h0, "R7");
    // R7 R4 reset state of indirect registers through the window
    sweep_ind("R7");
    wr(32'h0, 32'd12); chk(32'h4, 32'h8A, "R7");
    wr(32'h0, 32'd25); chk(32'h4, 32'hA0, "R7");

    // R2 R1 full-width store on plain words, junk in unused address bits
    for (int w = 0; w < 16; w++) begin
      if (w == 1 || w == 2 || w == 4) continue;
      wr(32'hABC0_0000 | (32'(w) << 2) | 32'h3, 32'hC3A5_0000 ^ (32'(w) * 32'h0101_1111));
    end
    for (int w = 0; w < 16; w++) chk_m((32'(w) << 2) | 32'h7FF0_0000, "R2");

    // R8 read-only direct word
    wr(32'h8, 32'hFFFF_FFFF);
    chk(32'h8, 32'h0, "R8");

    // R3 R5 R6 R4 window sweep, index with junk upper bits
    for (int i = 0; i < 32; i++) begin
      wr(32'h0, 32'hFFFF_FFE0 | 32'(i));
      wr(32'h4, 32'h5A5A_0000 | 32'((i * 37 + 11) & 8'hFF));
      chk_m(32'h4, "R3");
      chk_m(32'h0, "R3");
    end
    // R6 explicit version field values
    wr(32'h0, 32'd12);
    wr(32'h4, 32'hFF); chk(32'h4, 32'hCA, "R6");
    wr(32'h4, 32'h00); chk(32'h4, 32'h8A, "R6");
    // R5 read-only indirect registers
    wr(32'h0, 32'd11); wr(32'h4, 32'h77); chk(32'h4, 32'h00, "R5");
    wr(32'h0, 32'd25); wr(32'h4, 32'h33); chk(32'h4, 32'hA0, "R5");
    // R4 index 3 accepts a write but reads zero
    wr(32'h0, 32'd3); wr(32'h4, 32'hEE); chk(32'h4, 32'h0, "R4");

    // R12 bus activity without write enable
    @(negedge clk);
    addr = 32'h14; wdata = 32'hDEAD_BEEF; we = 1'b0;
    @(negedge clk);
    addr = 32'h10; wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    chk_m(32'h14, "R12");
    chk_m(32'h10, "R12");

    // R11 read enable low gives zero
    @(negedge clk);
    addr = 32'h14; re = 1'b0; #1;
    n_chk++;
    if (rdata !== 32'h0) begin
      n_fail++;
      $display("FAIL R11 got=%h exp=%h", rdata, 32'h0);
    end

    // R10 control write without reset bit
    wr(32'h10, 32'hFFFF_FF7E);
    chk(32'h10, 32'h7E, "R10");
    for (int w = 0; w < 16; w++) chk_m(32'(w) << 2, "R10");

    // R9 software reset
    wr(32'h0, 32'd7); wr(32'h4, 32'h5C);
    wr(32'h10, 32'hFFFF_FFFF);
    chk(32'h10, 32'h7F, "R9");
    for (int w = 0; w < 16; w++) chk_m(32'(w) << 2, "R9");
    sweep_ind("R9");

    // R7 hardware reset mid-run
    wr(32'h3C, 32'h1234_5678);
    wr(32'h0, 32'd5); wr(32'h4, 32'h99);
    @(negedge clk); rst_n = 1'b0; m_reset();
    @(negedge clk); rst_n = 1'b1;
    chk(32'h3C, 32'h0, "R7");
    chk(32'h10, 32'h0, "R7");
    sweep_ind("R7");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule